// File: doc/BRIEF.md
# Parallel OVSF Codeword Generator

This block turns a spreading-factor select and a code index into a whole orthogonal variable spreading factor (OVSF) channelization codeword, presented at once on a bus as wide as the largest supported code. The select gives the code depth `d` as log2 of the spreading factor, so the code length is `2^d`. Each chip comes from a fixed XOR network over the index bits, following the Hadamard structure. No table of codewords is stored.

A chip of +1 is carried as logic 0 and a chip of −1 as logic 1. The tree rule defines the codes. The root code of length 1 is a single 0. A code C of length L has two children of length 2L: child 2N is `[C C]` and child 2N+1 is `[C −C]`. Chip k sits on bit k of the bus. Bus positions at or beyond the selected length read 0.

A request strobe captures the select and the index. The codeword is then registered and flagged with a one-cycle valid pulse. A request with a select outside the supported depths is dropped. The output register keeps its last word until the next accepted request completes.

Top module: `ovsf_codegen`

## Requirements
- R1: After reset, `codeValid` is 0 and `codeWord` is all zeros.
- R2: A request is accepted when `reqValid` is 1 and `sfLog` is in the range MIN_LOG..MAX_LOG (defaults 2..9, so SF 4..512). If it is sampled at rising edge E, then `codeWord` updates and `codeValid` is 1 after edge E+1, for exactly one cycle unless another accepted request follows.
- R3: For depth d and index N, bit k of `codeWord` (k < 2^d) equals the parity of (k AND r). Here r is N bit-reversed over d bits. This is the same word the tree rule gives: root = 0, child 2N = [C C], child 2N+1 = [C −C], where −C inverts every bit. Bit value 1 means chip −1 and bit value 0 means chip +1.
- R4: Bits of `codeWord` at positions 2^d and above are 0.
- R5: Bits of `codeIdx` at positions d and above have no effect on the codeword.
- R6: A request with `sfLog` below MIN_LOG or above MAX_LOG is ignored. No `codeValid` pulse follows, and `codeWord` keeps its previous value.
- R7: `codeWord` holds its value in every cycle in which no accepted request completes.
- R8: Accepted requests on consecutive cycles each produce their own codeword, in request order, on consecutive cycles.
- R9: Chip 0 of every code is 0. Index 0 gives an all-zero code. Any other index gives exactly 2^(d−1) ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| sfLog | input | SFW (4) | Code depth d = log2(SF) |
| codeIdx | input | MAX_LOG (9) | Code index N |
| codeValid | output | 1 | One-cycle pulse marking a new codeword |
| codeWord | output | 2^MAX_LOG (512) | Codeword, chip k on bit k |

## Verification
The assertions run on every cycle. They check the two-edge latency from an accepted request to the valid pulse. They check that a dropped or absent request never produces a pulse, and that the word holds between updates. On each update they also check that the bits above the code length are zero, and that the number of −1 chips is 0 for index 0 and half the length otherwise.

Only the bench's scenarios can show that each codeword matches the tree rule chip for chip. The bench sweeps every depth from 4 to 512 chips and every index, with junk in the unused index bits. It also shows that out-of-range selects leave the word untouched, and that back-to-back requests come out in order.

// File: rtl/ovsf_pkg.sv
package ovsf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture select and index
    logic emit;   // register the computed codeword
  } ovsfStrobe_t;
endpackage

// File: rtl/ovsf_ctrl.sv
module ovsf_ctrl
  import ovsf_pkg::*;
#(
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 9,
  parameter int SFW     = $clog2(MAX_LOG + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reqValid,
  input  logic [SFW-1:0] sfLog,
  output ovsfStrobe_t    strobe,
  output logic           codeValid
);
  logic inRange;
  logic accept;
  logic loadQ;

  assign inRange = (sfLog >= SFW'(MIN_LOG)) && (sfLog <= SFW'(MAX_LOG));
  assign accept  = reqValid && inRange;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadQ     <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      loadQ     <= accept;
      codeValid <= loadQ;
    end
  end

  assign strobe.load = accept;
  assign strobe.emit = loadQ;

  // R2: an accepted request yields a pulse two edges later
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 codeValid);

  // R2: no request, no pulse
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> ##1 !codeValid);

  // R6: out-of-range select never produces a pulse
  assert_range_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ((sfLog < SFW'(MIN_LOG)) || (sfLog > SFW'(MAX_LOG)))) |=> ##1 !codeValid);
endmodule

// File: rtl/ovsf_datapath.sv
module ovsf_datapath
  import ovsf_pkg::*;
#(
  parameter int MAX_LOG = 9,
  parameter int SFW     = $clog2(MAX_LOG + 1),
  localparam int MAX_SF = 1 << MAX_LOG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ovsfStrobe_t        strobe,
  input  logic [SFW-1:0]     sfLog,
  input  logic [MAX_LOG-1:0] codeIdx,
  output logic [MAX_SF-1:0]  codeWord
);
  logic [SFW-1:0]     sfReg;
  logic [MAX_LOG-1:0] idxReg;
  logic [MAX_LOG-1:0] idxMasked;
  logic [MAX_LOG-1:0] fullRev;
  logic [MAX_LOG-1:0] revIdx;
  logic [SFW-1:0]     revShift;
  logic [MAX_SF-1:0]  nextWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfReg  <= '0;
      idxReg <= '0;
    end else if (strobe.load) begin
      sfReg  <= sfLog;
      idxReg <= codeIdx;
    end
  end

  // keep only the d low index bits, then reverse them over d bits
  generate
    for (genvar i = 0; i < MAX_LOG; i++) begin : g_idx
      assign idxMasked[i]         = idxReg[i] & (sfReg > SFW'(i));
      assign fullRev[MAX_LOG-1-i] = idxMasked[i];
    end
  endgenerate

  assign revShift = SFW'(MAX_LOG) - sfReg;
  assign revIdx   = fullRev >> revShift;

  // one parity network per chip position, gated by the code length
  generate
    for (genvar k = 0; k < MAX_SF; k++) begin : g_chip
      localparam logic [MAX_LOG-1:0] KPOS = MAX_LOG'(k);
      assign nextWord[k] = ((KPOS >> sfReg) == '0) ? (^(revIdx & KPOS)) : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) codeWord <= '0;
    else if (strobe.emit) codeWord <= nextWord;
  end

  // R4: nothing set above the selected code length
  assert_length_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.emit |=> ((codeWord >> (1 << $past(sfReg))) == '0));

  // R9: chip 0 is +1, and the weight is zero or half the length
  assert_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.emit |=> (!codeWord[0] &&
      ($countones(codeWord) == (($past(idxMasked) == '0) ? 0 : (1 << ($past(sfReg) - 1))))));

  // R7: the word only moves on an emit
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.emit |=> $stable(codeWord));
endmodule

// File: rtl/ovsf_codegen.sv
module ovsf_codegen
  import ovsf_pkg::*;
#(
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 9,
  localparam int SFW    = $clog2(MAX_LOG + 1),
  localparam int MAX_SF = 1 << MAX_LOG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [SFW-1:0]     sfLog,
  input  logic [MAX_LOG-1:0] codeIdx,
  output logic               codeValid,
  output logic [MAX_SF-1:0]  codeWord
);
  ovsfStrobe_t strobe;

  ovsf_ctrl #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SFW(SFW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .sfLog(sfLog),
    .strobe(strobe), .codeValid(codeValid)
  );

  ovsf_datapath #(.MAX_LOG(MAX_LOG), .SFW(SFW)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sfLog(sfLog),
    .codeIdx(codeIdx), .codeWord(codeWord)
  );
endmodule

// File: tb/ovsf_codegen_bench.sv
module ovsf_codegen_bench;
  localparam int PERIOD  = 10;
  localparam int MAX_LOG = 9;
  localparam int SFW     = 4;
  localparam int MAX_SF  = 1 << MAX_LOG;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reqValid = 1'b0;
  logic [SFW-1:0]     sfLog = '0;
  logic [MAX_LOG-1:0] codeIdx = '0;
  logic               codeValid;
  logic [MAX_SF-1:0]  codeWord;

  int checks = 0;
  int errors = 0;
  logic [MAX_SF-1:0] expW, prevW;

  ovsf_codegen u_ovsf_codegen (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .sfLog(sfLog),
    .codeIdx(codeIdx), .codeValid(codeValid), .codeWord(codeWord)
  );

  always #(PERIOD/2) clk = ~clk;

  // tree rule: child 2N = [C C], child 2N+1 = [C -C], chip k on bit k
  function automatic logic [MAX_SF-1:0] refCode(int d, int n);
    logic [MAX_SF-1:0] c = '0;
    int len = 1;
    for (int j = 1; j <= d; j++) begin
      logic b = 1'((n >> (d - j)) & 1);
      for (int p = 0; p < len; p++) c[len + p] = c[p] ^ b;
      len = len * 2;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [MAX_SF-1:0] act, input logic [MAX_SF-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one request, then check the pulse and the hold cycle after it
  task automatic oneReq(input int d, input logic [MAX_LOG-1:0] idx, input int n);
    @(negedge clk);
    reqValid = 1'b1; sfLog = SFW'(d); codeIdx = idx;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    expW = refCode(d, n);
    chk(codeValid == 1'b1, "R2 valid pulse", MAX_SF'(codeValid), MAX_SF'(1));
    chk(codeWord == expW, "R3 R4 R5 codeword", codeWord, expW);
    @(negedge clk);
    chk(codeValid == 1'b0, "R2 single pulse", MAX_SF'(codeValid), MAX_SF'(0));
    chk(codeWord == expW, "R7 hold", codeWord, expW);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    chk(codeValid == 1'b0, "R1 reset valid", MAX_SF'(codeValid), MAX_SF'(0));
    chk(codeWord == '0, "R1 reset word", codeWord, '0);
    rst_n = 1'b1;

    // full sweep of depths and indices; junk above bit d checks R5
    for (int d = 2; d <= MAX_LOG; d++) begin
      for (int n = 0; n < (1 << d); n++) begin
        logic [MAX_LOG-1:0] junk;
        junk = MAX_LOG'((32'h1A5 ^ n) << d);
        oneReq(d, junk | MAX_LOG'(n), n);
        chk(codeWord[0] == 1'b0 &&
            $countones(codeWord) == ((n == 0) ? 0 : (1 << (d - 1))),
            "R9 weight", codeWord, expW);
      end
    end

    // R6: out-of-range selects are dropped
    prevW = codeWord;
    for (int s = 0; s < 16; s++) begin
      if (s >= 2 && s <= MAX_LOG) continue;
      @(negedge clk);
      reqValid = 1'b1; sfLog = SFW'(s); codeIdx = 9'h155;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      chk(codeValid == 1'b0, "R6 no pulse", MAX_SF'(codeValid), MAX_SF'(0));
      chk(codeWord == prevW, "R6 word kept", codeWord, prevW);
    end

    // R8: three back-to-back requests
    @(negedge clk);
    reqValid = 1'b1; sfLog = 4'd3; codeIdx = 9'd5;
    @(negedge clk);
    sfLog = 4'd9; codeIdx = 9'd301;
    @(negedge clk);
    sfLog = 4'd2; codeIdx = 9'd3;
    expW = refCode(3, 5);
    chk(codeValid && codeWord == expW, "R8 first", codeWord, expW);
    @(negedge clk);
    reqValid = 1'b0;
    expW = refCode(9, 301);
    chk(codeValid && codeWord == expW, "R8 second", codeWord, expW);
    @(negedge clk);
    expW = refCode(2, 3);
    chk(codeValid && codeWord == expW, "R8 third", codeWord, expW);
    @(negedge clk);
    chk(!codeValid && codeWord == expW, "R8 R7 settle", codeWord, expW);

    finishRun();
  end
endmodule